// File: doc/BRIEF.md
# Four-Channel Shadowed PWM Generator with Brake Override

The block produces four pulse-width-modulated outputs from one shared 10-bit down counter. When the counter runs out it reloads a programmable period, so every channel repeats every period+1 clocks. Each channel has its own 10-bit compare value, which sets where its output falls within the cycle, and its own polarity-inversion bit. Software writes the period and compare values into holding (shadow) registers. Those values reach the counter and comparators only when software asks for a transfer, and the transfer takes place at the next underflow while the counter is running. Because the swap always falls on a cycle boundary, no output ever shows a cycle made from half old and half new settings.

A brake override forces all four outputs to programmed levels. It can act unconditionally, only while the counter is stopped, or when a synchronized external pin reaches a chosen level. A pin-triggered brake also stops the counter, so when the pin is released the outputs return to the levels they had before the brake. Software reaches the block through a byte-wide register port with a write strobe and a read path that does not wait for a clock edge.

Top module: `pwm4_brake`

## Requirements
- R1: The counter counts down by one on each clock while run is set. In the cycle it would pass zero it reloads the active period P, so every output repeats with a cycle of P+1 clocks. The first edge after run is set from reset is an underflow.
- R2: Take C as a channel's active compare value, with 0 < C <= P and C != 0x3FF. The channel's non-inverted level goes high on each underflow, stays high while the counter holds a value of C or more, and goes low once the counter drops below C. It is therefore high for P-C+1 clocks of each cycle.
- R3: A compare value of 0x3FF keeps the level permanently low. Otherwise a compare value of 0, or any value greater than P, keeps it permanently high.
- R4: When a channel's invert bit (control register bits 3:0, channel n at bit n) is set, that channel's output is the complement of its level.
- R5: Register map on the 4-bit address, all registers 8-bit. 0 holds period bits 7:0. 1 holds period bits 9:8 in bits 1:0. Addresses 2 to 5 hold compare bits 7:0 of channels 0 to 3. 6 holds compare bits 9:8 of all channels, two bits per channel, with channel n at bits 2n+1:2n. 7 is control: bit 7 run, bit 6 transfer, bits 3:0 invert. 8 is brake: bits 3:0 forced levels, bit 4 brake enable, bit 5 brake-when-halted, bit 6 pin brake, bit 7 pin polarity. Reads return the shadow contents and the live run and transfer bits. Bits with no field, and addresses 9 to 15, read as 0.
- R6: Period and compare writes go only to the shadows. When run and transfer are both set, the next underflow copies every shadow into the active set, and the new values take effect at that reload. Hardware clears the transfer bit at the same edge.
- R7: While run is clear a pending transfer never happens and the transfer bit stays set. Writing the control register with transfer clear before the next underflow cancels the pending transfer.
- R8: While run is clear the counter and all channel levels hold their values.
- R9: While a brake is active every output equals its forced-level bit. After a pin brake is released the outputs return to their levels from before the brake.
- R10: With brake enabled, the brake-when-halted and pin brake bits select the mode. Both clear gives an unconditional brake. Brake-when-halted alone brakes whenever run is clear. Pin brake alone brakes while the synchronized pin equals the polarity bit. Both set gives no brake. With brake disabled there is never a brake.
- R11: The brake pin passes through a two-stage synchronizer, so a pin change takes effect after two clock edges. A pin-triggered brake clears the run bit.
- R12: After reset every register is 0, the counter is 0 and every channel level is high, so all four outputs are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address for reads and writes |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for reg_addr, available without a clock edge |
| brake_pin | input | 1 | Asynchronous external brake request |
| pwm_out | output | 4 | PWM outputs, channel n on bit n |

## Verification
The assertions check on every cycle the counter's decrement and its reload to the active period, that counter and levels freeze while halted, that the transfer bit clears at a transferring underflow and survives while halted, that the 0x3FF and over-period compare cases hold their fixed level, that a pin brake stops the counter, and that braked outputs equal the forced levels. Only the bench's scenarios can show the full waveform shape: the high time of P-C+1 clocks over many period and compare combinations with mixed inversion, a transfer landing exactly on the underflow edge and not before it, cancellation of a pending transfer, each brake mode with its two-edge pin latency, and the return to pre-brake levels.

// File: rtl/pwm4_pkg.sv
package pwm4_pkg;

    localparam int NCH         = 4;          // PWM channels
    localparam int CW          = 10;         // counter / compare width
    localparam int DW          = 8;          // register data width
    localparam int AW          = 4;          // register address width
    localparam int HB          = CW - DW;    // high bits per value
    localparam int SYNC_STAGES = 2;          // brake pin synchronizer depth

    localparam int CTRL_RUN_BIT  = DW - 1;
    localparam int CTRL_XFER_BIT = DW - 2;

    localparam logic [AW-1:0] A_PER_LO  = AW'(0);
    localparam logic [AW-1:0] A_PER_HI  = AW'(1);
    localparam logic [AW-1:0] A_CMP_LO0 = AW'(2);
    localparam logic [AW-1:0] A_CMP_HI  = A_CMP_LO0 + AW'(NCH);
    localparam logic [AW-1:0] A_CTRL    = A_CMP_HI + AW'(1);
    localparam logic [AW-1:0] A_BRK     = A_CTRL + AW'(1);

    typedef logic [CW-1:0] cval_t;
    localparam cval_t CMAX = '1;

    typedef struct packed {
        logic           run;
        logic           xfer;
        logic [NCH-1:0] inv;
    } ctrl_t;

    typedef struct packed {
        logic           pol;
        logic           pin_en;
        logic           run_sense;
        logic           enable;
        logic [NCH-1:0] lvl;
    } brk_cfg_t;

    typedef enum logic [1:0] {
        BRK_NONE,
        BRK_ALWAYS,
        BRK_HALTED,
        BRK_PIN
    } brk_mode_t;

    // Channel level after the counter takes value nc.
    function automatic logic level_next(input cval_t nc, input cval_t per, input cval_t cmp);
        if (cmp == CMAX)
            return 1'b0;
        else if (cmp > per)
            return 1'b1;
        else
            return (nc >= cmp);
    endfunction

    function automatic brk_mode_t brk_mode(input brk_cfg_t c);
        if (!c.enable)
            return BRK_NONE;
        case ({c.run_sense, c.pin_en})
            2'b00:   return BRK_ALWAYS;
            2'b10:   return BRK_HALTED;
            2'b01:   return BRK_PIN;
            default: return BRK_NONE;
        endcase
    endfunction

endpackage

// File: rtl/pwm4_regs.sv
module pwm4_regs
    import pwm4_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     we,
    input  logic [AW-1:0]            addr,
    input  logic [DW-1:0]            wdata,
    input  logic                     clr_xfer,
    input  logic                     pin_stop,
    output cval_t                    sh_period,
    output logic [NCH-1:0][CW-1:0]   sh_cmp,
    output ctrl_t                    ctrl,
    output brk_cfg_t                 brk,
    output logic [DW-1:0]            rdata
);

    logic [DW-1:0]           per_lo;
    logic [HB-1:0]           per_hi;
    logic [NCH-1:0][DW-1:0]  cmp_lo;
    logic [NCH-1:0][HB-1:0]  cmp_hi;

    always_ff @(posedge clk) begin
        if (rst) begin
            per_lo <= '0;
            per_hi <= '0;
            cmp_lo <= '0;
            cmp_hi <= '0;
            ctrl   <= '0;
            brk    <= '0;
        end else begin
            if (we) begin
                if (addr == A_PER_LO) per_lo <= wdata;
                if (addr == A_PER_HI) per_hi <= wdata[HB-1:0];
                for (int i = 0; i < NCH; i++) begin
                    if (addr == A_CMP_LO0 + AW'(i)) cmp_lo[i] <= wdata;
                    if (addr == A_CMP_HI)           cmp_hi[i] <= wdata[i*HB +: HB];
                end
                if (addr == A_BRK) brk <= brk_cfg_t'(wdata);
            end
            if (we && addr == A_CTRL) begin
                ctrl.run  <= wdata[CTRL_RUN_BIT];
                ctrl.xfer <= wdata[CTRL_XFER_BIT];
                ctrl.inv  <= wdata[NCH-1:0];
            end else if (clr_xfer) begin
                ctrl.xfer <= 1'b0;
            end
            // a pin brake overrides any concurrent run write
            if (pin_stop) ctrl.run <= 1'b0;
        end
    end

    assign sh_period = {per_hi, per_lo};

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_cmp
            assign sh_cmp[g] = {cmp_hi[g], cmp_lo[g]};
        end
    endgenerate

    always_comb begin
        rdata = '0;
        case (addr)
            A_PER_LO: rdata = per_lo;
            A_PER_HI: rdata[HB-1:0] = per_hi;
            A_CMP_HI: begin
                for (int i = 0; i < NCH; i++) rdata[i*HB +: HB] = cmp_hi[i];
            end
            A_CTRL: begin
                rdata[CTRL_RUN_BIT]  = ctrl.run;
                rdata[CTRL_XFER_BIT] = ctrl.xfer;
                rdata[NCH-1:0]       = ctrl.inv;
            end
            A_BRK:   rdata = DW'(brk);
            default: rdata = '0;
        endcase
        for (int i = 0; i < NCH; i++) begin
            if (addr == A_CMP_LO0 + AW'(i)) rdata = cmp_lo[i];
        end
    end

endmodule

// File: rtl/pwm4_timebase.sv
module pwm4_timebase
    import pwm4_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     run,
    input  logic                     xfer,
    input  cval_t                    sh_period,
    input  logic [NCH-1:0][CW-1:0]   sh_cmp,
    output cval_t                    cnt,
    output cval_t                    act_period,
    output logic [NCH-1:0][CW-1:0]   act_cmp,
    output cval_t                    cnt_next,
    output cval_t                    per_eff,
    output logic [NCH-1:0][CW-1:0]   cmp_eff,
    output logic                     load
);

    logic uflow;

    assign uflow    = run && (cnt == '0);
    assign load     = uflow && xfer;
    // on a transferring underflow the new values apply to this reload
    assign per_eff  = load ? sh_period : act_period;
    assign cmp_eff  = load ? sh_cmp    : act_cmp;
    assign cnt_next = uflow ? per_eff : cnt - CW'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt        <= '0;
            act_period <= '0;
            act_cmp    <= '0;
        end else if (run) begin
            cnt <= cnt_next;
            if (load) begin
                act_period <= sh_period;
                act_cmp    <= sh_cmp;
            end
        end
    end

endmodule

// File: rtl/pwm4_channel.sv
module pwm4_channel
    import pwm4_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  step,
    input  cval_t cnt_next,
    input  cval_t per_eff,
    input  cval_t cmp_eff,
    input  logic  inv,
    input  logic  brake,
    input  logic  brk_level,
    output logic  lvl,
    output logic  pwm
);

    always_ff @(posedge clk) begin
        if (rst)
            lvl <= 1'b1;
        else if (step)
            lvl <= level_next(cnt_next, per_eff, cmp_eff);
    end

    assign pwm = brake ? brk_level : (lvl ^ inv);

endmodule

// File: rtl/pwm4_brake_ctl.sv
module pwm4_brake_ctl
    import pwm4_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     pin,
    input  brk_cfg_t cfg,
    input  logic     run,
    output logic     active,
    output logic     pin_stop
);

    logic [SYNC_STAGES-1:0] sync;
    logic                   pin_hit;
    brk_mode_t              mode;

    always_ff @(posedge clk) begin
        if (rst)
            sync <= '0;
        else
            sync <= {sync[SYNC_STAGES-2:0], pin};
    end

    assign pin_hit  = (sync[SYNC_STAGES-1] == cfg.pol);
    assign mode     = brk_mode(cfg);
    assign pin_stop = (mode == BRK_PIN) && pin_hit;
    assign active   = (mode == BRK_ALWAYS)
                   || ((mode == BRK_HALTED) && !run)
                   || pin_stop;

endmodule

// File: rtl/pwm4_brake.sv
module pwm4_brake
    import pwm4_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_we,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          brake_pin,
    output logic [NCH-1:0] pwm_out
);

    cval_t                   sh_period;
    logic [NCH-1:0][CW-1:0]  sh_cmp;
    ctrl_t                   ctrl;
    brk_cfg_t                brk;
    cval_t                   cnt;
    cval_t                   act_period;
    logic [NCH-1:0][CW-1:0]  act_cmp;
    cval_t                   cnt_next;
    cval_t                   per_eff;
    logic [NCH-1:0][CW-1:0]  cmp_eff;
    logic                    load;
    logic                    brake_act;
    logic                    pin_stop;
    logic                    run_q;
    logic                    xfer_q;
    logic [NCH-1:0]          lvl;
    logic [NCH-1:0]          brk_lvl;

    assign run_q   = ctrl.run;
    assign xfer_q  = ctrl.xfer;
    assign brk_lvl = brk.lvl;

    pwm4_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .we        (reg_we),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .clr_xfer  (load),
        .pin_stop  (pin_stop),
        .sh_period (sh_period),
        .sh_cmp    (sh_cmp),
        .ctrl      (ctrl),
        .brk       (brk),
        .rdata     (reg_rdata)
    );

    pwm4_timebase u_tb (
        .clk        (clk),
        .rst        (rst),
        .run        (run_q),
        .xfer       (xfer_q),
        .sh_period  (sh_period),
        .sh_cmp     (sh_cmp),
        .cnt        (cnt),
        .act_period (act_period),
        .act_cmp    (act_cmp),
        .cnt_next   (cnt_next),
        .per_eff    (per_eff),
        .cmp_eff    (cmp_eff),
        .load       (load)
    );

    pwm4_brake_ctl u_brk (
        .clk      (clk),
        .rst      (rst),
        .pin      (brake_pin),
        .cfg      (brk),
        .run      (run_q),
        .active   (brake_act),
        .pin_stop (pin_stop)
    );

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_ch
            pwm4_channel u_ch (
                .clk       (clk),
                .rst       (rst),
                .step      (run_q),
                .cnt_next  (cnt_next),
                .per_eff   (per_eff),
                .cmp_eff   (cmp_eff[g]),
                .inv       (ctrl.inv[g]),
                .brake     (brake_act),
                .brk_level (brk_lvl[g]),
                .lvl       (lvl[g]),
                .pwm       (pwm_out[g])
            );
        end
    endgenerate

endmodule

// File: rtl/pwm4_checker.sv
module pwm4_checker
    import pwm4_pkg::*;
(
    input logic                    clk,
    input logic                    rst,
    input logic                    reg_we,
    input logic [AW-1:0]           reg_addr,
    input logic                    run,
    input logic                    xfer,
    input cval_t                   cnt,
    input cval_t                   act_period,
    input logic [NCH-1:0][CW-1:0]  act_cmp,
    input logic [NCH-1:0]          lvl,
    input logic                    brake_act,
    input logic                    pin_stop,
    input logic [NCH-1:0]          brk_lvl,
    input logic [NCH-1:0]          pwm_out
);

    logic ctrl_wr;
    assign ctrl_wr = reg_we && (reg_addr == A_CTRL);

    assert_count_down_R1: assert property (@(posedge clk) disable iff (rst)
        (run && cnt != '0) |=> (cnt == $past(cnt) - CW'(1)));

    assert_reload_R1: assert property (@(posedge clk) disable iff (rst)
        (run && cnt == '0) |=> (cnt == act_period));

    assert_xfer_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (run && cnt == '0 && xfer && !ctrl_wr) |=> !xfer);

    assert_halted_keeps_xfer_R7: assert property (@(posedge clk) disable iff (rst)
        (!run && xfer && !ctrl_wr) |=> xfer);

    assert_halt_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !run |=> ($stable(cnt) && $stable(lvl)));

    assert_brake_levels_R9: assert property (@(posedge clk) disable iff (rst)
        brake_act |-> (pwm_out == brk_lvl));

    assert_pin_stops_run_R11: assert property (@(posedge clk) disable iff (rst)
        pin_stop |=> !run);

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_chk
            assert_const_low_R3: assert property (@(posedge clk) disable iff (rst)
                (run && !xfer && act_cmp[g] == CMAX) |=> !lvl[g]);
            assert_const_high_R3: assert property (@(posedge clk) disable iff (rst)
                (run && !xfer && act_cmp[g] != CMAX && act_cmp[g] > act_period) |=> lvl[g]);
        end
    endgenerate

endmodule

bind pwm4_brake pwm4_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .run        (run_q),
    .xfer       (xfer_q),
    .cnt        (cnt),
    .act_period (act_period),
    .act_cmp    (act_cmp),
    .lvl        (lvl),
    .brake_act  (brake_act),
    .pin_stop   (pin_stop),
    .brk_lvl    (brk_lvl),
    .pwm_out    (pwm_out)
);

// File: tb/pwm4_brake_tb_top.sv
module pwm4_brake_tb_top;
    import pwm4_pkg::*;

    localparam time CLK_PERIOD = 10;
    localparam int  WATCHDOG_CYCLES = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_we = 1'b0;
    logic [3:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       brake_pin = 1'b0;
    logic [3:0] pwm_out;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm4_brake dut_i (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .brake_pin (brake_pin),
        .pwm_out   (pwm_out)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // all tasks start and end just after a falling edge
    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic do_reset();
        rst = 1'b1; brake_pin = 1'b0;
        step(2);
        rst = 1'b0;
    endtask

    function automatic logic exp_lvl(input int p, input int c, input int k);
        if (c == 1023) return 1'b0;
        if (c > p)     return 1'b1;
        return ((p - ((k - 1) % (p + 1))) >= c);
    endfunction

    initial begin
        @(negedge clk);
        #(CLK_PERIOD * WATCHDOG_CYCLES);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic [3:0] held;
        int pers[4];
        int cmps[8];
        logic [3:0] inv;
        pers = '{0, 1, 2, 5};
        cmps = '{0, 1, 2, 3, 4, 5, 6, 1023};

        @(negedge clk);
        do_reset();

        // R12 reset state
        chk("R12", "outputs after reset", pwm_out, 4'hF);
        rd(A_CTRL, d); chk("R12", "control after reset", d, 8'h00);
        rd(A_BRK, d);  chk("R12", "brake cfg after reset", d, 8'h00);

        // R5 register map and readback
        wr(A_PER_LO, 8'h5A); rd(A_PER_LO, d); chk("R5", "period low", d, 8'h5A);
        wr(A_PER_HI, 8'hFF); rd(A_PER_HI, d); chk("R5", "period high", d, 8'h03);
        for (int i = 0; i < 4; i++) begin
            wr(A_CMP_LO0 + 4'(i), 8'(8'h11 * (i + 1)));
            rd(A_CMP_LO0 + 4'(i), d);
            chk("R5", "compare low", d, 8'(8'h11 * (i + 1)));
        end
        wr(A_CMP_HI, 8'hB4); rd(A_CMP_HI, d); chk("R5", "compare high pack", d, 8'hB4);
        wr(A_CTRL, 8'h4A);   rd(A_CTRL, d);   chk("R5", "control", d, 8'h4A);
        wr(A_BRK, 8'hA5);    rd(A_BRK, d);    chk("R5", "brake cfg", d, 8'hA5);
        rd(4'd9, d);  chk("R5", "unused address", d, 8'h00);
        rd(4'd15, d); chk("R5", "unused address", d, 8'h00);

        // R1 R2 R3 R4 sweep over period and compare values
        inv = 4'b1010;
        for (int pi = 0; pi < 4; pi++) begin
            for (int r = 0; r < 2; r++) begin
                int p;
                logic [7:0] hi;
                p = pers[pi];
                do_reset();
                wr(A_PER_LO, 8'(p));
                wr(A_PER_HI, 8'h00);
                hi = '0;
                for (int i = 0; i < 4; i++) begin
                    int c;
                    c = cmps[r*4 + i];
                    wr(A_CMP_LO0 + 4'(i), 8'(c & 255));
                    hi[2*i +: 2] = 2'((c >> 8) & 3);
                end
                wr(A_CMP_HI, hi);
                wr(A_CTRL, 8'hC0 | {4'h0, inv});
                for (int k = 1; k <= 2*(p+1) + 1; k++) begin
                    step(1);
                    for (int i = 0; i < 4; i++) begin
                        int c;
                        string tag;
                        c = cmps[r*4 + i];
                        if (c == 0 || c > p) tag = "R3";
                        else if (inv[i])     tag = "R4";
                        else                 tag = "R1 R2";
                        chk(tag, $sformatf("P=%0d C=%0d ch%0d k=%0d", p, c, i, k),
                            pwm_out[i], exp_lvl(p, c, k) ^ inv[i]);
                    end
                end
                rd(A_CTRL, d);
                chk("R6", "transfer bit cleared after underflow", d[6], 1'b0);
            end
        end

        // R6 transfer only at the underflow after the request
        do_reset();
        wr(A_PER_LO, 8'd7);
        wr(A_CTRL, 8'hC0);          // E0: run, transfer of cmp=0
        wr(A_CMP_LO0, 8'hFF);       // E1: underflow, counter 7
        wr(A_CMP_HI, 8'h03);        // E2: counter 6
        wr(A_CTRL, 8'hC0);          // E3: counter 5, transfer pending
        chk("R6", "old compare before underflow", pwm_out[0], 1'b1);
        rd(A_CTRL, d); chk("R6", "transfer pending", d[6], 1'b1);
        for (int k = 0; k < 5; k++) begin
            step(1);
            chk("R6", "no early transfer", pwm_out[0], 1'b1);
        end
        step(1);
        chk("R6", "new compare at underflow", pwm_out[0], 1'b0);
        rd(A_CTRL, d); chk("R6", "transfer auto-cleared", d[6], 1'b0);
        step(3);
        chk("R6", "new compare holds", pwm_out[0], 1'b0);

        // R7 transfer while halted, then cancelled
        do_reset();
        wr(A_PER_LO, 8'd3);
        wr(A_CMP_LO0, 8'hFF);
        wr(A_CMP_HI, 8'h03);
        wr(A_CTRL, 8'h40);
        step(4);
        rd(A_CTRL, d); chk("R7", "transfer stays set while halted", d, 8'h40);
        chk("R7", "no transfer while halted", pwm_out, 4'hF);
        wr(A_CTRL, 8'h80);
        for (int k = 0; k < 6; k++) begin
            step(1);
            chk("R7", "cancelled transfer keeps old compare", pwm_out[0], 1'b1);
        end

        // R8 halting holds outputs
        do_reset();
        wr(A_PER_LO, 8'd5);
        wr(A_CMP_LO0, 8'd3);
        wr(A_CTRL, 8'hC0);
        step(4);
        wr(A_CTRL, 8'h00);
        held = pwm_out;
        for (int k = 0; k < 6; k++) begin
            step(1);
            chk("R8", "output held while halted", pwm_out, held);
        end

        // R9 R10 R11 brake modes on a constant-level setup
        do_reset();
        wr(A_PER_LO, 8'd3);
        wr(A_CMP_LO0 + 4'd1, 8'hFF);
        wr(A_CMP_LO0 + 4'd3, 8'hFF);
        wr(A_CMP_HI, 8'hCC);
        wr(A_CTRL, 8'hCC);
        step(2);
        chk("R4", "constant levels with invert", pwm_out, 4'b1001);

        wr(A_BRK, 8'h16);
        chk("R10", "unconditional brake", pwm_out, 4'b0110);
        wr(A_BRK, 8'h00);
        chk("R9", "outputs after brake disabled", pwm_out, 4'b1001);

        wr(A_BRK, 8'h36);
        chk("R10", "halted-mode no brake while running", pwm_out, 4'b1001);
        wr(A_CTRL, 8'h0C);
        chk("R10", "halted-mode brake when stopped", pwm_out, 4'b0110);
        wr(A_CTRL, 8'h8C);
        chk("R10", "halted-mode release on run", pwm_out, 4'b1001);

        wr(A_BRK, 8'h76);
        step(3);
        chk("R10", "illegal mode gives no brake", pwm_out, 4'b1001);
        rd(A_CTRL, d); chk("R10", "illegal mode keeps run", d, 8'h8C);

        wr(A_BRK, 8'hD6);
        step(3);
        chk("R10", "pin brake idle", pwm_out, 4'b1001);
        brake_pin = 1'b1;
        step(1);
        chk("R11", "pin not yet through synchronizer", pwm_out, 4'b1001);
        step(1);
        chk("R11", "pin brake after two edges", pwm_out, 4'b0110);
        step(1);
        rd(A_CTRL, d); chk("R11", "pin brake clears run", d, 8'h0C);
        brake_pin = 1'b0;
        step(1);
        chk("R11", "release not yet through synchronizer", pwm_out, 4'b0110);
        step(1);
        chk("R9", "outputs resume pre-brake levels", pwm_out, 4'b1001);
        rd(A_CTRL, d); chk("R11", "run stays clear after release", d, 8'h0C);

        wr(A_BRK, 8'h56);
        brake_pin = 1'b1;
        step(3);
        chk("R10", "pin polarity mismatch gives no brake", pwm_out, 4'b1001);
        brake_pin = 1'b0;

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule